// File: doc/BRIEF.md
# Basic-Block Signature Control-Flow Monitor

This block sits beside a processor core and watches two of its buses: the instruction-fetch port and the data-memory write port. Instrumented software brackets each basic block with two stores to reserved addresses. The store to the entry address opens a block and zeroes a running signature. While the block is open, every fetched instruction word is XOR-folded into that signature. The store to the check address carries the signature that the compiler calculated for the block. The monitor compares it against the folded value and then closes the block.

A wrong jump shows up in one of two ways. It can corrupt the folded signature, or it can make the core fetch from outside the legal code window. A watchdog counts fetches since the last block entry and catches execution that is trapped in a loop. The first fault seen sets a sticky error flag and a two-bit cause code. Both hold until a synchronous clear is applied.

Internally a three-state controller tracks the block bracket. The states are ST_IDLE (no block open), ST_BLOCK (block open) and ST_FAULT (error latched). The transitions are:
- ENTER: ST_IDLE to ST_BLOCK, on an entry store.
- REENTER: ST_BLOCK to ST_BLOCK, on an entry store.
- CLOSE: ST_BLOCK to ST_IDLE, on a check store whose signature matches.
- TRIP: ST_IDLE or ST_BLOCK to ST_FAULT, on any detected fault.
- RELEASE: any state to ST_IDLE, on the clear input.

Top module: `cfsig_monitor`

## Requirements
- R1: The running signature is the XOR of every valid fetched instruction word since the last entry store. A fetch in the same cycle as the entry store is the first word of the new block.
- R2: A check store passes when its data equals the running signature XORed with any instruction fetched in the same cycle. A passing check leaves the error flag low and closes the block.
- R3: A check store whose data differs from that value sets err_o in the next cycle, with err_code_o = 1.
- R4: A check store that arrives while no block is open sets err_o with err_code_o = 1. No block is open after reset, after clear, or after a passing check.
- R5: A valid fetch whose address is below CODE_LO or above CODE_HI sets err_o in the next cycle, with err_code_o = 2. The bounds themselves are legal.
- R6: The watchdog counts valid fetches. An entry store zeroes it, and a fetch in the same cycle as that store is not counted. A valid fetch that arrives when 2**WD_W - 1 fetches have already been counted sets err_o with err_code_o = 3.
- R7: err_o and err_code_o hold their values until clear. Only the first cause is recorded.
- R8: When several faults occur in one cycle, the priority is code 2 first, then code 1, then code 3.
- R9: clr_i zeroes err_o and err_code_o in the next cycle. It also closes any open block and zeroes the signature and the watchdog. Clear wins over any fault seen in the same cycle.
- R10: A write to any address other than the entry and check addresses has no effect. A write with wr_vld_i low has no effect.
- R11: After reset, err_o = 0 and err_code_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of error and tracking state |
| fetch_vld_i | input | 1 | Instruction fetch valid |
| fetch_addr_i | input | AW | Fetch address |
| fetch_insn_i | input | DW | Fetched instruction word |
| wr_vld_i | input | 1 | Data write valid |
| wr_addr_i | input | AW | Data write address |
| wr_data_i | input | DW | Data write value |
| err_o | output | 1 | Sticky error flag |
| err_code_o | output | 2 | Cause: 1 signature, 2 address range, 3 watchdog |

## Verification
Every fault is decided combinationally from the inputs and the state at a clock edge. It appears on err_o and err_code_o straight after that same edge, so a result is due exactly one cycle after its stimulus. Clear takes effect on the same edge as its own cycle.

The bench drives inputs a couple of nanoseconds after each rising edge and samples the outputs right after the edge that closes that cycle. Each check therefore reads the cycle in which the result is due. The bench keeps its own expected signature and watchdog count, and uses them to sweep block lengths, single-bit signature corruptions, range edges and the watchdog boundary.

// File: rtl/cfsig_pkg.sv
package cfsig_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_SIG   = 2'd1,
        CAUSE_RANGE = 2'd2,
        CAUSE_WDOG  = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BLOCK = 2'd1,
        ST_FAULT = 2'd2
    } mon_state_e;

endpackage

// File: rtl/cfsig_bus_decode.sv
module cfsig_bus_decode #(
    parameter int          AW       = 32,
    parameter logic [AW-1:0] RST_ADDR = '0,
    parameter logic [AW-1:0] CHK_ADDR = '0
) (
    input  logic          wr_vld_i,
    input  logic [AW-1:0] wr_addr_i,
    output logic          is_entry_o,
    output logic          is_check_o
);
    always_comb begin
        is_entry_o = wr_vld_i && (wr_addr_i == RST_ADDR);
        is_check_o = wr_vld_i && (wr_addr_i == CHK_ADDR);
    end
endmodule

// File: rtl/cfsig_range_chk.sv
module cfsig_range_chk #(
    parameter int            AW      = 32,
    parameter logic [AW-1:0] CODE_LO = '0,
    parameter logic [AW-1:0] CODE_HI = '1
) (
    input  logic          fetch_vld_i,
    input  logic [AW-1:0] fetch_addr_i,
    output logic          out_of_range_o
);
    always_comb begin
        out_of_range_o = fetch_vld_i &&
                         ((fetch_addr_i < CODE_LO) || (fetch_addr_i > CODE_HI));
    end
endmodule

// File: rtl/cfsig_sig_accum.sv
module cfsig_sig_accum #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          hold_i,
    input  logic          entry_i,
    input  logic          check_i,
    input  logic          fetch_vld_i,
    input  logic [DW-1:0] fetch_insn_i,
    input  logic [DW-1:0] chk_data_i,
    output logic          match_o
);
    logic [DW-1:0] sig_q;
    logic [DW-1:0] word;
    logic [DW-1:0] folded;

    always_comb begin
        word    = fetch_vld_i ? fetch_insn_i : '0;
        folded  = sig_q ^ word;
        match_o = (chk_data_i == folded);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_q <= '0;
        end else if (clear_i) begin
            sig_q <= '0;
        end else if (hold_i) begin
            sig_q <= sig_q;
        end else if (entry_i) begin
            sig_q <= word;
        end else if (check_i) begin
            sig_q <= '0;
        end else begin
            sig_q <= folded;
        end
    end
endmodule

// File: rtl/cfsig_watchdog.sv
module cfsig_watchdog #(
    parameter int WD_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic hold_i,
    input  logic rearm_i,
    input  logic tick_i,
    output logic overflow_o
);
    localparam logic [WD_W-1:0] CNT_MAX = '1;

    logic [WD_W-1:0] cnt_q;

    always_comb begin
        overflow_o = !hold_i && !rearm_i && tick_i && (cnt_q == CNT_MAX);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i || rearm_i) begin
            cnt_q <= '0;
        end else if (!hold_i && tick_i && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cfsig_monitor.sv
module cfsig_monitor
    import cfsig_pkg::*;
#(
    parameter int            AW       = 32,
    parameter int            DW       = 32,
    parameter int            WD_W     = 16,
    parameter logic [AW-1:0] RST_ADDR = 32'hFFFF_FF00,
    parameter logic [AW-1:0] CHK_ADDR = 32'hFFFF_FF04,
    parameter logic [AW-1:0] CODE_LO  = 32'h0000_1000,
    parameter logic [AW-1:0] CODE_HI  = 32'h0000_7FFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          fetch_vld_i,
    input  logic [AW-1:0] fetch_addr_i,
    input  logic [DW-1:0] fetch_insn_i,
    input  logic          wr_vld_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    output logic          err_o,
    output logic [1:0]    err_code_o
);
    mon_state_e state_q, state_d;
    logic       is_entry, is_check, oor, sig_match, wd_ovf, frozen;
    logic       ev_range, ev_sig, ev_wd, ev_any;
    logic       err_q;
    cause_e     code_q;

    cfsig_bus_decode #(.AW(AW), .RST_ADDR(RST_ADDR), .CHK_ADDR(CHK_ADDR)) u_dec (
        .wr_vld_i   (wr_vld_i),
        .wr_addr_i  (wr_addr_i),
        .is_entry_o (is_entry),
        .is_check_o (is_check)
    );

    cfsig_range_chk #(.AW(AW), .CODE_LO(CODE_LO), .CODE_HI(CODE_HI)) u_rng (
        .fetch_vld_i    (fetch_vld_i),
        .fetch_addr_i   (fetch_addr_i),
        .out_of_range_o (oor)
    );

    assign frozen = (state_q == ST_FAULT);

    cfsig_sig_accum #(.DW(DW)) u_acc (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (clr_i),
        .hold_i       (frozen),
        .entry_i      (is_entry),
        .check_i      (is_check),
        .fetch_vld_i  (fetch_vld_i),
        .fetch_insn_i (fetch_insn_i),
        .chk_data_i   (wr_data_i),
        .match_o      (sig_match)
    );

    cfsig_watchdog #(.WD_W(WD_W)) u_wd (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clr_i),
        .hold_i     (frozen),
        .rearm_i    (is_entry),
        .tick_i     (fetch_vld_i),
        .overflow_o (wd_ovf)
    );

    // Fault events, evaluated only while monitoring is live.
    always_comb begin
        ev_range = !frozen && oor;
        ev_sig   = !frozen && is_check && ((state_q == ST_IDLE) || !sig_match);
        ev_wd    = !frozen && wd_ovf;
        ev_any   = ev_range || ev_sig || ev_wd;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d = ST_IDLE;                          // RELEASE
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (ev_any)        state_d = ST_FAULT; // TRIP
                    else if (is_entry) state_d = ST_BLOCK; // ENTER
                end
                ST_BLOCK: begin
                    if (ev_any)        state_d = ST_FAULT; // TRIP
                    else if (is_check) state_d = ST_IDLE;  // CLOSE
                    else               state_d = ST_BLOCK; // REENTER / stay
                end
                ST_FAULT: state_d = ST_FAULT;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register: first cause wins, fixed priority inside a cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            code_q <= CAUSE_NONE;
        end else if (clr_i) begin
            err_q  <= 1'b0;
            code_q <= CAUSE_NONE;
        end else if (ev_any) begin
            err_q <= 1'b1;
            if (ev_range)    code_q <= CAUSE_RANGE;
            else if (ev_sig) code_q <= CAUSE_SIG;
            else             code_q <= CAUSE_WDOG;
        end
    end

    assign err_o      = err_q;
    assign err_code_o = code_q;

endmodule

// File: rtl/cfsig_monitor_chk.sv
module cfsig_monitor_chk #(
    parameter int            AW       = 32,
    parameter logic [AW-1:0] RST_ADDR = '0,
    parameter logic [AW-1:0] CHK_ADDR = '0,
    parameter logic [AW-1:0] CODE_LO  = '0,
    parameter logic [AW-1:0] CODE_HI  = '1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clr_i,
    input logic          fetch_vld_i,
    input logic [AW-1:0] fetch_addr_i,
    input logic          wr_vld_i,
    input logic [AW-1:0] wr_addr_i,
    input logic          err_o,
    input logic [1:0]    err_code_o
);
    logic bad_addr, quiet;
    assign bad_addr = fetch_vld_i && ((fetch_addr_i < CODE_LO) || (fetch_addr_i > CODE_HI));
    assign quiet    = !fetch_vld_i &&
                      !(wr_vld_i && ((wr_addr_i == RST_ADDR) || (wr_addr_i == CHK_ADDR)));

    AST_STICKY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !clr_i) |=> err_o); // R7
    AST_STICKY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !clr_i) |=> $stable(err_code_o)); // R7
    AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!err_o && err_code_o == 2'd0)); // R9
    AST_RANGE_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_o && !clr_i && bad_addr) |=> (err_o && err_code_o == 2'd2)); // R5
    AST_CODE_CONSISTENT: assert property (@(posedge clk) disable iff (!rst_n)
        err_o == (err_code_o != 2'd0)); // R11
    AST_QUIET_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_o && !clr_i && quiet) |=> !err_o); // R10
endmodule

bind cfsig_monitor cfsig_monitor_chk #(
    .AW(AW), .RST_ADDR(RST_ADDR), .CHK_ADDR(CHK_ADDR),
    .CODE_LO(CODE_LO), .CODE_HI(CODE_HI)
) u_chk (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
    .fetch_vld_i(fetch_vld_i), .fetch_addr_i(fetch_addr_i),
    .wr_vld_i(wr_vld_i), .wr_addr_i(wr_addr_i),
    .err_o(err_o), .err_code_o(err_code_o)
);

// File: tb/sim_cfsig_monitor.sv
`timescale 1ns/1ps
module sim_cfsig_monitor;
    localparam int          WD_W = 4;
    localparam logic [31:0] RSTA = 32'hFFFF_FF00;
    localparam logic [31:0] CHKA = 32'hFFFF_FF04;
    localparam logic [31:0] LO   = 32'h0000_1000;
    localparam logic [31:0] HI   = 32'h0000_7FFF;
    localparam logic [31:0] PC   = 32'h0000_2000;

    logic        clk = 0, rst_n = 0, clr_i = 0;
    logic        fetch_vld_i = 0, wr_vld_i = 0;
    logic [31:0] fetch_addr_i = 0, fetch_insn_i = 0, wr_addr_i = 0, wr_data_i = 0;
    logic        err_o;
    logic [1:0]  err_code_o;
    int checks = 0, fails = 0;
    logic [31:0] exp;

    always #4 clk = ~clk;

    cfsig_monitor #(.WD_W(WD_W), .RST_ADDR(RSTA), .CHK_ADDR(CHKA),
                    .CODE_LO(LO), .CODE_HI(HI)) u0 (
        .clk(clk), .rst_n(rst_n), .clr_i(clr_i),
        .fetch_vld_i(fetch_vld_i), .fetch_addr_i(fetch_addr_i), .fetch_insn_i(fetch_insn_i),
        .wr_vld_i(wr_vld_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .err_o(err_o), .err_code_o(err_code_o)
    );

    task automatic cyc(input logic fv, input logic [31:0] fa, input logic [31:0] fi,
                       input logic wv, input logic [31:0] wa, input logic [31:0] wd,
                       input logic c);
        fetch_vld_i = fv; fetch_addr_i = fa; fetch_insn_i = fi;
        wr_vld_i = wv; wr_addr_i = wa; wr_data_i = wd; clr_i = c;
        @(posedge clk); #2;
        fetch_vld_i = 0; wr_vld_i = 0; clr_i = 0;
    endtask

    task automatic fetch(input logic [31:0] w); cyc(1, PC, w, 0, 0, 0, 0); endtask
    task automatic entry();                      cyc(0, 0, 0, 1, RSTA, 0, 0); endtask
    task automatic check(input logic [31:0] d);  cyc(0, 0, 0, 1, CHKA, d, 0); endtask
    task automatic clear();                      cyc(0, 0, 0, 0, 0, 0, 1); endtask

    task automatic expect_out(input string req, input logic e, input logic [1:0] c);
        checks++;
        if (err_o !== e || err_code_o !== c) begin
            fails++;
            $display("FAIL %s err=%0b code=%0d expected err=%0b code=%0d",
                     req, err_o, err_code_o, e, c);
        end
    endtask

    function automatic logic [31:0] wgen(input int a, input int b);
        return (32'h9E37_79B9 * (a + 1)) ^ (32'h0101_0101 << (b % 8)) ^ b;
    endfunction

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog timeout");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2; repeat (3) @(posedge clk); #2; rst_n = 1;
        expect_out("R11 reset", 0, 0);

        // R4: check with no block open
        check(0);
        expect_out("R4 check after reset", 1, 1);
        clear();
        expect_out("R9 clear", 0, 0);

        // R1/R2: block length sweep, plain framing
        for (int n = 0; n <= 8; n++) begin
            entry(); exp = 0;
            for (int i = 0; i < n; i++) begin fetch(wgen(n, i)); exp ^= wgen(n, i); end
            check(exp);
            expect_out("R2 pass plain", 0, 0);
        end
        // R1/R2: same-cycle fetch on entry and on check
        for (int n = 2; n <= 8; n++) begin
            cyc(1, PC, wgen(n, 0), 1, RSTA, 0, 0); exp = wgen(n, 0);
            for (int i = 1; i < n - 1; i++) begin fetch(wgen(n, i)); exp ^= wgen(n, i); end
            exp ^= wgen(n, n - 1);
            cyc(1, PC, wgen(n, n - 1), 1, CHKA, exp, 0);
            expect_out("R1 same-cycle fold", 0, 0);
        end
        // R4: second check after a passing one
        check(0);
        expect_out("R4 check after close", 1, 1);
        clear();

        // R3: every single-bit corruption
        for (int b = 0; b < 32; b++) begin
            entry(); exp = 0;
            for (int i = 0; i < 3; i++) begin fetch(wgen(b, i)); exp ^= wgen(b, i); end
            check(exp ^ (32'h1 << b));
            expect_out("R3 bit flip", 1, 1);
            clear();
        end

        // R5: range edges
        cyc(1, LO - 1, 0, 0, 0, 0, 0); expect_out("R5 below LO", 1, 2); clear();
        cyc(1, LO, 0, 0, 0, 0, 0);     expect_out("R5 at LO", 0, 0);
        cyc(1, HI, 0, 0, 0, 0, 0);     expect_out("R5 at HI", 0, 0);
        cyc(1, HI + 1, 0, 0, 0, 0, 0); expect_out("R5 above HI", 1, 2); clear();
        cyc(1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0); expect_out("R5 top", 1, 2); clear();
        cyc(0, 0, 0, 0, 0, 0, 0);      expect_out("R5 invalid fetch ignored", 0, 0);

        // R6: watchdog boundary after entry
        entry();
        for (int i = 0; i < (1 << WD_W) - 1; i++) fetch(i);
        expect_out("R6 below limit", 0, 0);
        fetch(0);
        expect_out("R6 overflow", 1, 3);
        clear();
        // R6: entry re-arms, same-cycle fetch not counted
        for (int i = 0; i < 10; i++) fetch(i);
        cyc(1, PC, 0, 1, RSTA, 0, 0);
        for (int i = 0; i < (1 << WD_W) - 1; i++) fetch(i);
        expect_out("R6 rearm", 0, 0);
        fetch(0);
        expect_out("R6 overflow after rearm", 1, 3);
        clear();

        // R8: range beats signature
        entry(); fetch(32'hA5);
        cyc(1, HI + 1, 0, 1, CHKA, 32'h0, 0);
        expect_out("R8 range over sig", 1, 2); clear();
        // R8: signature beats watchdog
        entry();
        for (int i = 0; i < (1 << WD_W) - 1; i++) fetch(0);
        cyc(1, PC, 0, 1, CHKA, 32'h1, 0);
        expect_out("R8 sig over wdog", 1, 1); clear();

        // R7: sticky, first cause kept
        check(0);
        expect_out("R7 first cause", 1, 1);
        cyc(1, 0, 0, 0, 0, 0, 0);
        expect_out("R7 second cause ignored", 1, 1);
        repeat (3) cyc(0, 0, 0, 0, 0, 0, 0);
        expect_out("R7 hold", 1, 1);

        // R9: clear wins and closes block, zeroes signature and watchdog
        cyc(1, 0, 0, 0, 0, 0, 1);
        expect_out("R9 clear wins", 0, 0);
        entry(); fetch(32'h55);
        clear();
        check(0);
        expect_out("R9 block closed", 1, 1);
        clear();
        for (int i = 0; i < (1 << WD_W) - 1; i++) fetch(i);
        expect_out("R9 watchdog zeroed", 0, 0);
        fetch(0);
        expect_out("R9 watchdog zeroed limit", 1, 3);
        clear();

        // R10: ignored writes
        entry(); fetch(32'h1234_5678);
        cyc(0, 0, 0, 1, RSTA + 8, 32'hDEAD, 0);
        expect_out("R10 other addr", 0, 0);
        cyc(0, 0, 0, 0, CHKA, 32'hBAD, 0);
        expect_out("R10 invalid check", 0, 0);
        cyc(0, 0, 0, 0, RSTA, 0, 0);
        fetch(32'h0F0F_0000);
        check(32'h1234_5678 ^ 32'h0F0F_0000);
        expect_out("R10 signature untouched", 0, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule